// File: doc/BRIEF.md
# Deferred-Latch Error Status Register

This block is the error status register of an interrupt controller. Software sees a visible status word that changes only when software writes to the register. Error events from the controller's detectors, and from the block's own vector checks, are OR-ed into a hidden pending word. A register write throws away its data, moves the pending word into the visible word and clears pending, all on one clock edge. Reads return the visible word, so a handler that follows the usual write-then-read sequence always sees a consistent snapshot.

When pending bits are newly set, the block raises a one-cycle request on an error interrupt line. The request carries a programmable vector and can be masked. The trigger rule is chosen by a parameter. In per-bit mode, every pending bit that goes from 0 to 1 causes a request. In aggregate mode, a request is raised only when the whole pending word goes from zero to nonzero. The block also screens outgoing fixed-mode sends and incoming accepted interrupts for vectors below 16. Such traffic is blocked and flagged as an error.

Top module: `err_status_reg`

## Requirements
- R1: An error event ORs its bit into the pending word. Pending bits stay set until a status write. The visible word does not change when events arrive.
- R2: A status write (`wr_sel_i`=0) ignores `wr_data_i`. On the same edge it copies pending into the visible word and clears pending.
- R3: With `rd_sel_i`=0, `rd_data_o` shows the visible word. Reads repeated without a status write return the same value, even while new errors arrive.
- R4: While `x2_mode_i`=1, a status write with nonzero data is ignored and both words keep their values. A zero write performs the transfer.
- R5: In per-bit mode (`PER_BIT`=1), `irq_req_o` pulses for one cycle, one clock after any event that sets a pending bit that was clear. An event whose bits are all already pending raises no request.
- R6: In aggregate mode (`PER_BIT`=0), a request is raised only when pending goes from all-zero to nonzero.
- R7: The configuration word (`wr_sel_i`/`rd_sel_i`=1) holds the vector in bits 7:0 and the mask in bit 16. It resets to mask=1, vector=0. While the mask is set, errors still accumulate but no request is raised.
- R8: If a request is due while unmasked but the vector is below 16, no request is raised. Bit 6 (receive-illegal) is set in pending instead. `irq_vec_o` is never below 16 when `irq_req_o` is high.
- R9: A send with `snd_fixed_i`=1 and a vector below 16 drives `snd_ok_o` low in the same cycle and sets pending bit 5 (send-illegal). Non-fixed sends and vectors of 16 and above pass.
- R10: An accepted incoming interrupt with a vector below 16 drives `rcv_ok_o` low and sets pending bit 6.
- R11: An error arriving in the same cycle as a status write lands in the freshly cleared pending word and is not lost. The visible word takes the old pending value.
- R12: After reset, the visible word, the pending word and `irq_req_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 status, 1 configuration |
| wr_data_i | input | REG_W | Write data |
| rd_sel_i | input | 1 | Read target: 0 status, 1 configuration |
| rd_data_o | output | REG_W | Read data |
| x2_mode_i | input | 1 | Strict mode: only zero status writes are legal |
| err_evt_i | input | REG_W | Error event bits from detectors |
| snd_vld_i | input | 1 | Outgoing send presented |
| snd_fixed_i | input | 1 | Outgoing send uses fixed delivery |
| snd_vec_i | input | VEC_W | Outgoing send vector |
| snd_ok_o | output | 1 | Outgoing send allowed |
| rcv_vld_i | input | 1 | Incoming interrupt presented |
| rcv_vec_i | input | VEC_W | Incoming interrupt vector |
| rcv_ok_o | output | 1 | Incoming interrupt accepted |
| irq_req_o | output | 1 | One-cycle error interrupt request |
| irq_vec_o | output | VEC_W | Vector of the request |

## Verification
The gate outputs `snd_ok_o` and `rcv_ok_o` follow their inputs in the same cycle. A status or configuration write, an error event, or a vector violation shows up in the registers and in `irq_req_o` one clock later. The bench drives inputs after a falling edge and compares every output shortly afterwards against a behavioural model. The model is advanced at each rising edge, so every result is checked in the cycle it is due. Two instances, one in per-bit mode and one in aggregate mode, see the same stimulus.

// File: rtl/errst_pkg.sv
// Shared selector encoding for the error status register.
package errst_pkg;
    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_VECCFG = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/errst_vec_check.sv
// Screens one vector stream for values below the legal floor.
// Assumes the check applies only when `apply` is high (fixed mode, or always for receive).
module errst_vec_check #(
    parameter int VEC_W   = 8,
    parameter int MIN_VEC = 16
) (
    input  logic             vld,
    input  logic             apply,
    input  logic [VEC_W-1:0] vec,
    output logic             illegal,
    output logic             pass
);
    localparam logic [VEC_W-1:0] MIN_V = VEC_W'(MIN_VEC);

    // Flag an illegal vector and block the transfer.
    always_comb begin
        illegal = vld && apply && (vec < MIN_V);
        pass    = vld && !illegal;
    end
endmodule

// File: rtl/errst_trigger.sv
// Decides whether an event batch warrants an error request.
// Assumes `base` is pending after any same-cycle clear.
module errst_trigger #(
    parameter int REG_W   = 32,
    parameter bit PER_BIT = 1'b1
) (
    input  logic [REG_W-1:0] base,
    input  logic [REG_W-1:0] evt,
    output logic             fire
);
    generate
        if (PER_BIT) begin : g_per_bit
            // Any bit going from clear to set triggers.
            always_comb fire = |(evt & ~base);
        end else begin : g_aggregate
            // Only an empty word becoming nonempty triggers.
            always_comb fire = (base == '0) && (evt != '0);
        end
    endgenerate
endmodule

// File: rtl/errst_latch.sv
// Holds the hidden pending word and the software-visible word.
// Assumes `swap` is already qualified as a legal status write.
module errst_latch #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             swap,
    input  logic [REG_W-1:0] add_bits,
    output logic [REG_W-1:0] base,
    output logic [REG_W-1:0] pend_q,
    output logic [REG_W-1:0] vis_q
);
    // Pending as seen by this cycle's events: cleared by a swap.
    always_comb base = swap ? '0 : pend_q;

    // Accumulate events and perform the transfer atomically.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            vis_q  <= '0;
        end else begin
            pend_q <= base | add_bits;
            if (swap) vis_q <= pend_q;
        end
    end
endmodule

// File: rtl/err_status_reg.sv
// Error status register with deferred visibility and error request generation.
// Assumes single-cycle register accesses; reads are combinational.
module err_status_reg
    import errst_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int VEC_W    = 8,
    parameter int MIN_VEC  = 16,
    parameter int SEND_BIT = 5,
    parameter int RECV_BIT = 6,
    parameter int MASK_BIT = 16,
    parameter bit PER_BIT  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             rd_sel_i,
    output logic [REG_W-1:0] rd_data_o,
    input  logic             x2_mode_i,
    input  logic [REG_W-1:0] err_evt_i,
    input  logic             snd_vld_i,
    input  logic             snd_fixed_i,
    input  logic [VEC_W-1:0] snd_vec_i,
    output logic             snd_ok_o,
    input  logic             rcv_vld_i,
    input  logic [VEC_W-1:0] rcv_vec_i,
    output logic             rcv_ok_o,
    output logic             irq_req_o,
    output logic [VEC_W-1:0] irq_vec_o
);
    localparam logic [VEC_W-1:0] MIN_V    = VEC_W'(MIN_VEC);
    localparam logic [REG_W-1:0] SEND_ONE = REG_W'(1) << SEND_BIT;
    localparam logic [REG_W-1:0] RECV_ONE = REG_W'(1) << RECV_BIT;

    logic             snd_bad, rcv_bad;
    logic             swap, cfg_wr;
    logic [REG_W-1:0] evt_all, add_bits, base, pend_q, vis_q, cfg_word;
    logic             fire, go, bad_vec;
    logic [VEC_W-1:0] vec_q;
    logic             mask_q;

    errst_vec_check #(.VEC_W(VEC_W), .MIN_VEC(MIN_VEC)) u_snd_chk (
        .vld(snd_vld_i), .apply(snd_fixed_i), .vec(snd_vec_i),
        .illegal(snd_bad), .pass(snd_ok_o)
    );

    errst_vec_check #(.VEC_W(VEC_W), .MIN_VEC(MIN_VEC)) u_rcv_chk (
        .vld(rcv_vld_i), .apply(1'b1), .vec(rcv_vec_i),
        .illegal(rcv_bad), .pass(rcv_ok_o)
    );

    // Decode register writes; strict mode accepts only a zero status write.
    always_comb begin
        swap   = wr_en_i && (wr_sel_i == SEL_STATUS) && (!x2_mode_i || wr_data_i == '0);
        cfg_wr = wr_en_i && (wr_sel_i == SEL_VECCFG);
    end

    // Gather every error source into one event word.
    always_comb begin
        evt_all = err_evt_i;
        if (snd_bad) evt_all = evt_all | SEND_ONE;
        if (rcv_bad) evt_all = evt_all | RECV_ONE;
    end

    errst_trigger #(.REG_W(REG_W), .PER_BIT(PER_BIT)) u_trig (
        .base(base), .evt(evt_all), .fire(fire)
    );

    // Apply the mask and divert a request with an illegal vector into an error bit.
    always_comb begin
        go       = fire && !mask_q;
        bad_vec  = go && (vec_q < MIN_V);
        add_bits = evt_all | (bad_vec ? RECV_ONE : '0);
    end

    errst_latch #(.REG_W(REG_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .swap(swap), .add_bits(add_bits),
        .base(base), .pend_q(pend_q), .vis_q(vis_q)
    );

    // Configuration register: vector and mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q  <= '0;
            mask_q <= 1'b1;
        end else if (cfg_wr) begin
            vec_q  <= wr_data_i[VEC_W-1:0];
            mask_q <= wr_data_i[MASK_BIT];
        end
    end

    // Registered one-cycle error request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req_o <= 1'b0;
            irq_vec_o <= '0;
        end else begin
            irq_req_o <= go && !bad_vec;
            irq_vec_o <= vec_q;
        end
    end

    // Assemble the configuration word for reads.
    always_comb begin
        cfg_word                = '0;
        cfg_word[VEC_W-1:0]     = vec_q;
        cfg_word[MASK_BIT]      = mask_q;
    end

    // Read multiplexer.
    always_comb rd_data_o = (rd_sel_i == SEL_VECCFG) ? cfg_word : vis_q;
endmodule

// File: rtl/errst_checker.sv
// Temporal checks for err_status_reg, attached by bind.
module errst_checker #(
    parameter int REG_W    = 32,
    parameter int VEC_W    = 8,
    parameter int MIN_VEC  = 16,
    parameter int SEND_BIT = 5,
    parameter int RECV_BIT = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             swap,
    input logic [REG_W-1:0] evt_all,
    input logic [REG_W-1:0] pend_q,
    input logic [REG_W-1:0] vis_q,
    input logic             mask_q,
    input logic             irq_req_o,
    input logic [VEC_W-1:0] irq_vec_o,
    input logic             snd_vld_i,
    input logic             snd_fixed_i,
    input logic [VEC_W-1:0] snd_vec_i,
    input logic             rcv_vld_i,
    input logic [VEC_W-1:0] rcv_vec_i
);
    localparam logic [VEC_W-1:0] MIN_V    = VEC_W'(MIN_VEC);
    localparam logic [REG_W-1:0] RECV_ONE = REG_W'(1) << RECV_BIT;

    p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
    p_vis_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |=> $stable(vis_q));
    p_swap_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> (vis_q == $past(pend_q)));
    p_swap_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> ((pend_q & ~$past(evt_all) & ~RECV_ONE) == '0));
    p_evt_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_all != '0) |=> ((pend_q & $past(evt_all)) == $past(evt_all)));
    p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |=> !irq_req_o);
    p_vec_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (irq_vec_o >= MIN_V));
    p_send_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_vld_i && snd_fixed_i && (snd_vec_i < MIN_V)) |=> pend_q[SEND_BIT]);
    p_recv_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_vld_i && (rcv_vec_i < MIN_V)) |=> pend_q[RECV_BIT]);
endmodule

bind err_status_reg errst_checker #(
    .REG_W(REG_W), .VEC_W(VEC_W), .MIN_VEC(MIN_VEC),
    .SEND_BIT(SEND_BIT), .RECV_BIT(RECV_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .swap(swap), .evt_all(evt_all),
    .pend_q(pend_q), .vis_q(vis_q), .mask_q(mask_q),
    .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o),
    .snd_vld_i(snd_vld_i), .snd_fixed_i(snd_fixed_i), .snd_vec_i(snd_vec_i),
    .rcv_vld_i(rcv_vld_i), .rcv_vec_i(rcv_vec_i)
);

// File: tb/err_status_reg_bench.sv
// Bench: behavioural model compared on every cycle; index 1 per-bit, index 0 aggregate.
module err_status_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, x2 = 1'b0;
    logic [31:0] wr_data = '0, err_evt = '0;
    logic        snd_vld = 1'b0, snd_fixed = 1'b0, rcv_vld = 1'b0;
    logic [7:0]  snd_vec = '0, rcv_vec = '0;

    logic [31:0] rd_o  [2];
    logic        snd_ok[2], rcv_ok[2], irq[2];
    logic [7:0]  ivec  [2];

    always #10 clk = ~clk;

    err_status_reg #(.PER_BIT(1'b1)) u_err_status_reg (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .rd_sel_i(rd_sel), .rd_data_o(rd_o[1]), .x2_mode_i(x2), .err_evt_i(err_evt),
        .snd_vld_i(snd_vld), .snd_fixed_i(snd_fixed), .snd_vec_i(snd_vec), .snd_ok_o(snd_ok[1]),
        .rcv_vld_i(rcv_vld), .rcv_vec_i(rcv_vec), .rcv_ok_o(rcv_ok[1]),
        .irq_req_o(irq[1]), .irq_vec_o(ivec[1])
    );

    err_status_reg #(.PER_BIT(1'b0)) u_err_status_reg_agg (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .rd_sel_i(rd_sel), .rd_data_o(rd_o[0]), .x2_mode_i(x2), .err_evt_i(err_evt),
        .snd_vld_i(snd_vld), .snd_fixed_i(snd_fixed), .snd_vec_i(snd_vec), .snd_ok_o(snd_ok[0]),
        .rcv_vld_i(rcv_vld), .rcv_vec_i(rcv_vec), .rcv_ok_o(rcv_ok[0]),
        .irq_req_o(irq[0]), .irq_vec_o(ivec[0])
    );

    // Model state
    int unsigned n_tests = 0, n_fail = 0;
    string       cur_req = "R12";
    bit          finished = 1'b0;
    logic [31:0] m_vis[2], m_pend[2];
    logic        m_irq[2];
    logic [7:0]  m_ivec[2];
    logic [7:0]  m_vec;
    logic        m_mask;

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        for (int m = 0; m < 2; m++) begin
            chk($sformatf("irq[%0d]", m), 32'(irq[m]), 32'(m_irq[m]));
            if (m_irq[m]) chk($sformatf("ivec[%0d]", m), 32'(ivec[m]), 32'(m_ivec[m]));
            chk($sformatf("rd[%0d]", m), rd_o[m],
                rd_sel ? ((32'(m_mask) << 16) | 32'(m_vec)) : m_vis[m]);
            chk($sformatf("snd_ok[%0d]", m), 32'(snd_ok[m]),
                32'(snd_vld && !(snd_fixed && snd_vec < 8'd16)));
            chk($sformatf("rcv_ok[%0d]", m), 32'(rcv_ok[m]), 32'(rcv_vld && rcv_vec >= 8'd16));
        end
    endtask

    task automatic model_edge();
        logic [31:0] evt, base;
        logic        swp, fire, go, bad;
        if (!rst_n) begin
            for (int m = 0; m < 2; m++) begin
                m_vis[m] = '0; m_pend[m] = '0; m_irq[m] = 1'b0; m_ivec[m] = '0;
            end
            m_vec = '0; m_mask = 1'b1;
            return;
        end
        evt = err_evt;
        if (snd_vld && snd_fixed && snd_vec < 8'd16) evt[5] = 1'b1;
        if (rcv_vld && rcv_vec < 8'd16) evt[6] = 1'b1;
        swp = wr_en && !wr_sel && (!x2 || wr_data == 0);
        for (int m = 0; m < 2; m++) begin
            base = swp ? 32'd0 : m_pend[m];
            if (swp) m_vis[m] = m_pend[m];
            fire = (m == 1) ? ((evt & ~base) != 0) : (base == 0 && evt != 0);
            go   = fire && !m_mask;
            bad  = go && (m_vec < 8'd16);
            m_irq[m]  = go && !bad;
            m_ivec[m] = m_vec;
            m_pend[m] = base | evt | (bad ? 32'h40 : 32'h0);
        end
        if (wr_en && wr_sel) begin
            m_vec  = wr_data[7:0];
            m_mask = wr_data[16];
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_sel = 0; wr_data = '0; err_evt = '0;
        snd_vld = 0; snd_fixed = 0; snd_vec = '0; rcv_vld = 0; rcv_vec = '0;
    endtask

    // One cycle: check current outputs, advance model at the edge, return after falling edge.
    task automatic cyc();
        #1 compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        idle();
    endtask

    task automatic wr_status(logic [31:0] d);
        wr_en = 1; wr_sel = 0; wr_data = d; cyc();
    endtask

    task automatic wr_cfg(logic [7:0] v, logic msk);
        wr_en = 1; wr_sel = 1; wr_data = (32'(msk) << 16) | 32'(v); cyc();
    endtask

    task automatic evt(logic [31:0] e);
        err_evt = e; cyc();
    endtask

    initial begin
        idle();
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); model_edge(); @(negedge clk);
        end
        rst_n = 1'b1;

        cur_req = "R12"; cyc(); cyc();
        rd_sel = 1; cyc(); rd_sel = 0;

        cur_req = "R7";  evt(32'h8); cyc();
        rd_sel = 1; cyc(); rd_sel = 0;
        cur_req = "R2";  wr_status(32'hFFFF_FFFF); cyc();
        cur_req = "R3";  cyc(); cyc();

        cur_req = "R5";  wr_cfg(8'h40, 1'b0); rd_sel = 1; cyc(); rd_sel = 0;
        wr_status(32'h0);
        evt(32'h1); cyc();
        evt(32'h1); cyc();
        evt(32'h2); cyc();
        evt(32'h6); cyc();
        cur_req = "R6";  evt(32'h100); cyc();
        wr_status(32'h0); evt(32'h10); cyc();

        cur_req = "R1";  evt(32'h8000_0000); cyc(); cyc();
        cur_req = "R3";  cyc(); cyc();

        cur_req = "R11"; err_evt = 32'h400; wr_status(32'h0); cyc();
        err_evt = 32'h400; wr_status(32'h1); cyc();

        cur_req = "R4";  x2 = 1; evt(32'h800); wr_status(32'h5); cyc();
        wr_status(32'h0); cyc(); x2 = 0;

        cur_req = "R9";  wr_status(0);
        snd_vld = 1; snd_fixed = 1; snd_vec = 8'd5; cyc();
        snd_vld = 1; snd_fixed = 1; snd_vec = 8'd16; cyc();
        snd_vld = 1; snd_fixed = 0; snd_vec = 8'd5; cyc();
        wr_status(0); cyc();

        cur_req = "R10"; rcv_vld = 1; rcv_vec = 8'd15; cyc();
        rcv_vld = 1; rcv_vec = 8'd16; cyc();
        wr_status(0); cyc();

        cur_req = "R8";  wr_cfg(8'd3, 1'b0); wr_status(0);
        evt(32'h80); cyc(); wr_status(0); cyc();
        wr_cfg(8'd16, 1'b0); evt(32'h200); cyc();

        cur_req = "R7";  wr_cfg(8'h50, 1'b1); wr_status(0); evt(32'h3); cyc(); wr_status(0); cyc();

        cur_req = "R5";  wr_cfg(8'h50, 1'b0);
        for (int i = 0; i < 400; i++) begin
            err_evt   = ($urandom % 4 == 0) ? (32'h1 << ($urandom % 12)) : 32'h0;
            wr_en     = ($urandom % 8 == 0);
            wr_sel    = ($urandom % 6 == 0);
            wr_data   = wr_sel ? ((32'($urandom % 2) << 16) | 32'(8'($urandom))) : 32'($urandom % 2);
            x2        = ($urandom % 2 == 0);
            rd_sel    = ($urandom % 3 == 0);
            snd_vld   = ($urandom % 5 == 0); snd_fixed = $urandom % 2; snd_vec = 8'($urandom % 32);
            rcv_vld   = ($urandom % 5 == 0); rcv_vec = 8'($urandom % 32);
            cyc();
            x2 = 0; rd_sel = 0;
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule